// File: doc/BRIEF.md
# Event Combiner Interrupt Controller

This block gathers single-cycle event pulses from across a subsystem and turns them into a small set of interrupt lines for one CPU. The block has 128 event index positions, arranged as four groups of 32. Indices 0 to 3 are held back as names for the four combined events, so 124 real event inputs remain. A rising edge on an event input sets a sticky flag bit. The flag stays set until the CPU clears it by writing a one to it, or until reset.

Each of the 12 interrupt outputs has a 7-bit select field. A select value from 4 to 127 ties the output directly to that event's flag. A select value from 0 to 3 ties the output to the combined event of that group. The combined event is the OR of the group's flags that are not masked. Because the flags are sticky, a combined line falls only when software clears the contributing flags, and it rises again only on a new rising edge.

The block also watches each output for events that are lost. When a new edge arrives on an event feeding an output that is already high, the block records the output's number in an error status word. The error line is the OR of that status with external error inputs, gated by a single enable bit.

Top module: `evc_top`

## Requirements
- R1: A 0-to-1 change on `evt_i[i]` (i from 4 to 127), seen at a rising clock edge, sets flag bit i%32 of flag word i/32 at that edge. An input held high after its flag is cleared does not set the flag again.
- R2: Register reads are combinational. Addresses 0 to 3 return flag words 0 to 3.
- R3: Writing to addresses 0 to 3 clears every flag bit written as one. Bits written as zero keep their value.
- R4: A set flag bit stays set until it is cleared as in R3 or by reset.
- R5: Inputs `evt_i[3:0]` are ignored. Flag word 0 bits 3:0 always read zero.
- R6: If an edge sets a flag bit in the same cycle that a write clears it, the bit ends up set.
- R7: Addresses 4 to 7 hold the mask words for groups 0 to 3, with reset value all ones. Combined event g is the OR of flag word g AND NOT mask word g.
- R8: Addresses 8 to 19 hold the 7-bit select fields of outputs 0 to 11, with reset value 0. Output o drives combined event s when s < 4, and flag s otherwise.
- R9: Error status is at address 20, with bit o for output o. Bit o sets when a new edge reaches an unmasked event feeding output o while `irq_o[o]` is high. Writing one to a status bit clears it.
- R10: Address 21 bit 0 is the error enable, with reset value 0. `err_irq_o` equals enable AND (any error status bit OR any `ext_err_i` bit).
- R11: After reset, all flags, outputs and status read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 128 | Event inputs; bits 3:0 unused |
| ext_err_i | input | 2 | External error sources |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 12 | CPU interrupt lines |
| err_irq_o | output | 1 | Aggregated error interrupt |

## Verification
A software clear of a flag word and a new edge on the same flag can land on the same clock edge. The bench forces this by raising the event in the same cycle that it writes the clear. The flag must read back as set afterwards. A second collision occurs when an edge arrives on a line that is already pending. Here the flag update and the error-status update happen on the same edge. The bench checks that the status bit of exactly that output is set, and that it reaches the error line only once the enable is set.

// File: rtl/evc_pkg.sv
package evc_pkg;
    localparam int NUM_GRP = 4;
    localparam int GRP_W   = 32;
    localparam int NUM_EVT = NUM_GRP * GRP_W;
    localparam int NUM_OUT = 12;
    localparam int SEL_W   = $clog2(NUM_EVT);
    localparam int GI_W    = $clog2(NUM_GRP);
    localparam int IDX_W   = $clog2(NUM_OUT);
    localparam int ADDR_W  = 5;

    localparam logic [ADDR_W-1:0] A_FLAG = 5'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 5'd4;
    localparam logic [ADDR_W-1:0] A_SEL  = 5'd8;
    localparam logic [ADDR_W-1:0] A_ERR  = 5'd20;
    localparam logic [ADDR_W-1:0] A_EN   = 5'd21;

    typedef logic [NUM_GRP-1:0][GRP_W-1:0] words_t;
    typedef logic [NUM_OUT-1:0][SEL_W-1:0] sels_t;

    typedef enum logic [2:0] {K_FLAG, K_MASK, K_SEL, K_ERR, K_EN, K_NONE} rkind_e;

    typedef struct packed {
        rkind_e           kind;
        logic [IDX_W-1:0] idx;
    } dec_t;

    function automatic dec_t decode(logic [ADDR_W-1:0] a);
        dec_t d;
        d.kind = K_NONE;
        d.idx  = '0;
        if (a < A_MASK) begin
            d.kind = K_FLAG; d.idx = IDX_W'(a - A_FLAG);
        end else if (a < A_SEL) begin
            d.kind = K_MASK; d.idx = IDX_W'(a - A_MASK);
        end else if (a < A_ERR) begin
            d.kind = K_SEL;  d.idx = IDX_W'(a - A_SEL);
        end else if (a == A_ERR) begin
            d.kind = K_ERR;
        end else if (a == A_EN) begin
            d.kind = K_EN;
        end
        return d;
    endfunction
endpackage

// File: rtl/evc_flags.sv
module evc_flags #(
    parameter int NG = 4,
    parameter int GW = 32,
    parameter int NR = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [NG*GW-1:0] evt_i,
    input  logic [NG*GW-1:0] clr_i,
    output logic [NG*GW-1:0] flag_o,
    output logic [NG*GW-1:0] rise_o
);
    localparam int NE = NG * GW;
    localparam logic [NE-1:0] LIVE = {{(NE-NR){1'b1}}, {NR{1'b0}}};

    logic [NE-1:0] evt_q, flag_q;

    assign rise_o = evt_i & ~evt_q & LIVE;
    assign flag_o = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            evt_q  <= '0;
            flag_q <= '0;
        end else begin
            evt_q  <= evt_i;
            flag_q <= (flag_q & ~clr_i) | rise_o;
        end
    end

    assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        (flag_q & $past(flag_q & ~clr_i)) == $past(flag_q & ~clr_i));

    assert_set_beats_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(rise_o & clr_i) & ~flag_q) == '0);

    assert_clear_takes_R3: assert property (@(posedge clk) disable iff (rst)
        (flag_q & $past(clr_i & ~rise_o)) == '0);

    assert_reserved_zero_R5: assert property (@(posedge clk) disable iff (rst)
        flag_q[NR-1:0] == '0);
endmodule

// File: rtl/evc_combine.sv
module evc_combine #(
    parameter int NG = 4,
    parameter int GW = 32
) (
    input  logic [NG*GW-1:0] flag_i,
    input  logic [NG*GW-1:0] rise_i,
    input  logic [NG*GW-1:0] mask_i,
    output logic [NG-1:0]    comb_o,
    output logic [NG-1:0]    hit_o
);
    for (genvar g = 0; g < NG; g++) begin : g_grp
        logic [GW-1:0] live;
        assign live      = ~mask_i[g*GW +: GW];
        assign comb_o[g] = |(flag_i[g*GW +: GW] & live);
        assign hit_o[g]  = |(rise_i[g*GW +: GW] & live);
    end
endmodule

// File: rtl/evc_map.sv
module evc_map #(
    parameter int NG  = 4,
    parameter int NE  = 128,
    parameter int NO  = 12,
    parameter int SW  = 7
) (
    input  logic [NO-1:0][SW-1:0] sel_i,
    input  logic [NE-1:0]         flag_i,
    input  logic [NE-1:0]         rise_i,
    input  logic [NG-1:0]         comb_i,
    input  logic [NG-1:0]         hit_i,
    output logic [NO-1:0]         irq_o,
    output logic [NO-1:0]         drop_o
);
    localparam int GB = $clog2(NG);

    for (genvar o = 0; o < NO; o++) begin : g_out
        logic [SW-1:0] s;
        logic          is_comb, new_hit;
        assign s        = sel_i[o];
        assign is_comb  = ~|s[SW-1:GB];
        assign irq_o[o] = is_comb ? comb_i[s[GB-1:0]] : flag_i[s];
        assign new_hit  = is_comb ? hit_i[s[GB-1:0]] : rise_i[s];
        assign drop_o[o] = new_hit & irq_o[o];
    end
endmodule

// File: rtl/evc_top.sv
module evc_top
    import evc_pkg::*;
#(
    parameter int NUM_EXT = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EXT-1:0] ext_err_i,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [GRP_W-1:0]   wdata_i,
    output logic [GRP_W-1:0]   rdata_o,
    output logic [NUM_OUT-1:0] irq_o,
    output logic               err_irq_o
);
    dec_t         dec;
    words_t       mask_q, clr_w, flag_w;
    sels_t        sel_q;
    logic [NUM_OUT-1:0] err_q, drop;
    logic               en_q;
    logic [NUM_EVT-1:0] flag, rise;
    logic [NUM_GRP-1:0] comb, hit;

    assign dec = decode(addr_i);

    always_comb begin
        clr_w = '0;
        if (wr_en_i && dec.kind == K_FLAG) clr_w[dec.idx[GI_W-1:0]] = wdata_i;
    end

    evc_flags #(.NG(NUM_GRP), .GW(GRP_W), .NR(NUM_GRP)) u_flags (
        .clk(clk), .rst(rst), .evt_i(evt_i), .clr_i(clr_w),
        .flag_o(flag), .rise_o(rise)
    );

    evc_combine #(.NG(NUM_GRP), .GW(GRP_W)) u_comb (
        .flag_i(flag), .rise_i(rise), .mask_i(mask_q),
        .comb_o(comb), .hit_o(hit)
    );

    evc_map #(.NG(NUM_GRP), .NE(NUM_EVT), .NO(NUM_OUT), .SW(SEL_W)) u_map (
        .sel_i(sel_q), .flag_i(flag), .rise_i(rise), .comb_i(comb), .hit_i(hit),
        .irq_o(irq_o), .drop_o(drop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '1;
            sel_q  <= '0;
            err_q  <= '0;
            en_q   <= 1'b0;
        end else begin
            if (wr_en_i && dec.kind == K_MASK) mask_q[dec.idx[GI_W-1:0]] <= wdata_i;
            if (wr_en_i && dec.kind == K_SEL)  sel_q[dec.idx] <= wdata_i[SEL_W-1:0];
            if (wr_en_i && dec.kind == K_EN)   en_q <= wdata_i[0];
            err_q <= (err_q & ~((wr_en_i && dec.kind == K_ERR) ? wdata_i[NUM_OUT-1:0]
                                                               : {NUM_OUT{1'b0}})) | drop;
        end
    end

    assign flag_w    = flag;
    assign err_irq_o = en_q & ((|err_q) | (|ext_err_i));

    always_comb begin
        rdata_o = '0;
        case (dec.kind)
            K_FLAG:  rdata_o = flag_w[dec.idx[GI_W-1:0]];
            K_MASK:  rdata_o = mask_q[dec.idx[GI_W-1:0]];
            K_SEL:   rdata_o = {{(GRP_W-SEL_W){1'b0}}, sel_q[dec.idx]};
            K_ERR:   rdata_o = {{(GRP_W-NUM_OUT){1'b0}}, err_q};
            K_EN:    rdata_o = {{(GRP_W-1){1'b0}}, en_q};
            default: rdata_o = '0;
        endcase
    end

    assert_drop_needs_pending_R9: assert property (@(posedge clk) disable iff (rst)
        (err_q & ~$past(err_q) & ~$past(irq_o)) == '0);

    assert_err_quiet_when_off_R10: assert property (@(posedge clk) disable iff (rst)
        $past(!en_q) && !en_q |-> !err_irq_o);
endmodule

// File: tb/sim_evc_top.sv
module sim_evc_top;
    import evc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [NUM_EVT-1:0] evt = '0;
    logic [1:0]         ext_err = '0;
    logic               wr_en = 1'b0;
    logic [ADDR_W-1:0]  addr = '0;
    logic [GRP_W-1:0]   wdata = '0;
    logic [GRP_W-1:0]   rdata;
    logic [NUM_OUT-1:0] irq;
    logic               err_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    evc_top #(.NUM_EXT(2)) u0 (
        .clk(clk), .rst(rst), .evt_i(evt), .ext_err_i(ext_err),
        .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .err_irq_o(err_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        addr = ADDR_W'(a);
        #1;
        d = rdata;
    endtask

    task automatic pulse(input int e);
        @(negedge clk); evt[e] = 1'b1;
        @(negedge clk); evt[e] = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog act=timeout exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11 / R7 / R8 reset values
        chk("R11 irq", 32'(irq), 32'h0);
        chk("R11 err_irq", 32'(err_irq), 32'h0);
        for (int g = 0; g < 4; g++) begin
            rd(g, d);     chk("R11 flag", d, 32'h0);
            rd(4 + g, d); chk("R7 mask reset", d, 32'hFFFF_FFFF);
        end
        rd(8, d);  chk("R8 sel reset", d, 32'h0);
        rd(20, d); chk("R11 err status", d, 32'h0);

        // R1 R2 R3 R8: sweep every live event through a direct mapping
        for (int e = 4; e < 128; e++) begin
            int o = e % 12;
            wr(8 + o, 32'(e));
            pulse(e);
            chk("R8 direct irq", 32'(irq), 32'h1 << o);
            rd(e / 32, d);
            chk("R1 flag set", d, 32'h1 << (e % 32));
            if (e % 16 == 0) begin
                wr(e / 32, 32'h0);
                rd(e / 32, d);
                chk("R3 zero write keeps", d, 32'h1 << (e % 32));
                repeat (3) @(negedge clk);
                rd(e / 32, d);
                chk("R4 flag sticky", d, 32'h1 << (e % 32));
            end
            wr(e / 32, 32'h1 << (e % 32));
            rd(e / 32, d);
            chk("R3 clear flag", d, 32'h0);
            chk("R3 irq falls", 32'(irq), 32'h0);
        end

        // R5 reserved inputs ignored
        for (int e = 0; e < 4; e++) pulse(e);
        rd(0, d);
        chk("R5 reserved", d, 32'h0);

        // R7 combined event on output 3 from group 2, bits 5 and 9 unmasked
        wr(6, ~32'h0000_0220);
        wr(8 + 3, 32'd2);
        pulse(64 + 7);
        chk("R7 masked no irq", 32'(irq[3]), 32'h0);
        rd(2, d); chk("R7 masked flag", d, 32'h80);
        pulse(64 + 5);
        chk("R7 combined irq", 32'(irq[3]), 32'h1);
        rd(20, d); chk("R9 no drop on idle", d, 32'h0);
        wr(2, 32'h20);
        chk("R7 combined falls", 32'(irq[3]), 32'h0);
        rd(2, d); chk("R7 masked kept", d, 32'h80);

        // R1 held level does not reassert after clear
        @(negedge clk); evt[64 + 9] = 1'b1;
        @(negedge clk);
        chk("R1 level set", 32'(irq[3]), 32'h1);
        wr(2, 32'h200);
        @(negedge clk);
        chk("R1 held no reset", 32'(irq[3]), 32'h0);
        evt[64 + 9] = 1'b0;
        @(negedge clk);

        // R9 R10 dropped event while pending
        pulse(64 + 5);
        chk("R9 pending", 32'(irq[3]), 32'h1);
        pulse(64 + 9);
        rd(20, d); chk("R9 drop status", d, 32'h8);
        chk("R10 disabled", 32'(err_irq), 32'h0);
        wr(21, 32'h1);
        chk("R10 enabled", 32'(err_irq), 32'h1);
        wr(20, 32'h0);
        rd(20, d); chk("R9 zero write keeps", d, 32'h8);
        wr(20, 32'h8);
        rd(20, d); chk("R9 w1c", d, 32'h0);
        chk("R10 clear drops line", 32'(err_irq), 32'h0);
        ext_err = 2'b10; #1;
        chk("R10 external", 32'(err_irq), 32'h1);
        ext_err = 2'b00;
        wr(21, 32'h0);
        ext_err = 2'b01; #1;
        chk("R10 external gated", 32'(err_irq), 32'h0);
        ext_err = 2'b00;

        // R6 set beats clear in one cycle
        wr(2, 32'hFFFF_FFFF);
        pulse(64 + 6);
        rd(2, d); chk("R6 pre", d, 32'h40);
        @(negedge clk);
        evt[64 + 6] = 1'b1;
        wr_en = 1'b1; addr = ADDR_W'(2); wdata = 32'h40;
        @(negedge clk);
        wr_en = 1'b0; evt[64 + 6] = 1'b0;
        rd(2, d); chk("R6 set wins", d, 32'h40);
        wr(2, 32'h40);
        rd(2, d); chk("R3 final clear", d, 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule